// File: doc/BRIEF.md
# Pre-Vertical-Sync Pulse Generator

This block drives an active-high pulse that opens a programmable number of half-lines ahead of each vertical sync and stays high for a programmable number of half-lines. The block cannot wait for the sync edge and then delay from it, because the pulse has to come before the sync. It counts half-lines inside each field instead, and predicts where the next sync will land from the field length of the selected 50/60 Hz standard. From that prediction it places the pulse backwards in time.

A half-line strobe advances the count. A vertical sync marker that arrives with a strobe restarts the field, so the prediction follows the incoming signal. If no marker arrives, the counter wraps at the nominal field length, and that wrap also counts as a field start. The 8-bit control byte and the standard select are sampled only at a field start. A register write therefore never cuts or glitches a pulse that is already under way.

Top module: `vsp_top`

## Requirements
- R1: While `rst` is high at a clock edge, `pre_vs_pulse` goes low after that edge, the half-line index goes to 0, and the active width becomes 0. The output therefore stays low until a field start has loaded a control byte.
- R2: At each clock edge where `hl_stb` is high, the half-line index advances by one. When `vs_mark` is also high at that edge, the index goes to 0 instead and a field start occurs. `vs_mark` has no effect without `hl_stb`.
- R3: With no marker, the index wraps from FIELD_HL_50-1 to 0 when the latched standard is 0 (50 Hz), and from FIELD_HL_60-1 to 0 when it is 1 (60 Hz). Each wrap is a field start.
- R4: Bits 3..0 of `ctrl_byte` give a lead code C. The pulse rises at the strobe that enters half-line index N-(C+3), where N is the active field length. So the pulse starts C+3 half-lines before the predicted sync.
- R5: Bits 7..4 of `ctrl_byte` give the width W in half-lines, and a field that ends by wrap holds the pulse high for exactly W strobes when W is at most C+3. W=0 keeps the output low for the whole field.
- R6: When W exceeds C+3, the pulse is cut off at the predicted sync: it is high for C+3 half-lines and is low at index 0.
- R7: `ctrl_byte` and `std_60` are sampled only at a field start. Changes made inside a field do not affect that field's pulse or length.
- R8: `pre_vs_pulse` is registered and changes only at clock edges where `hl_stb` is high. At that edge it shows whether the half-line just entered lies inside the pulse.
- R9: A marker that comes earlier than predicted drops the pulse at once, because index 0 is never inside the pulse, and starts a new field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hl_stb | input | 1 | Half-line strobe, one clock wide |
| vs_mark | input | 1 | Vertical sync marker, honoured only together with `hl_stb` |
| std_60 | input | 1 | Standard select: 0 = 50 Hz field length, 1 = 60 Hz field length |
| ctrl_byte | input | 8 | [7:4] pulse width, [3:0] lead code (lead = code + 3) |
| pre_vs_pulse | output | 1 | Registered pre-sync pulse |

## Verification
The bench builds the block with FIELD_HL_50=61 and FIELD_HL_60=47 in place of 625 and 525. With these short fields it can run dozens of complete fields, wraps and standard changes within a short run. Both field lengths stay above the largest lead of 18 half-lines, so every lead and width code, including cut-off at the sync, remains reachable. The strobe arrives every second clock, which leaves idle cycles in which the output must hold still.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  localparam int CODE_W    = 4;
  localparam int CTRL_W    = 2 * CODE_W;
  localparam int LEAD_BASE = 3;

  // Field order is fixed by the control byte: width in the high nibble.
  typedef struct packed {
    logic [CODE_W-1:0] width;
    logic [CODE_W-1:0] lead;
  } vsp_cfg_t;
endpackage

// File: rtl/vsp_hl_counter.sv
module vsp_hl_counter #(
  parameter int HL_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic            vs,
  input  logic [HL_W-1:0] field_len,
  output logic [HL_W-1:0] cnt,
  output logic [HL_W-1:0] cnt_next,
  output logic            field_start
);
  logic at_end;

  always_comb begin
    at_end      = (cnt >= field_len - HL_W'(1));
    field_start = stb && (vs || at_end);
    if (vs || at_end) cnt_next = '0;
    else              cnt_next = cnt + HL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (stb) cnt <= cnt_next;
  end
endmodule

// File: rtl/vsp_cfg_shadow.sv
module vsp_cfg_shadow
  import vsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic              std_in,
  output vsp_cfg_t          cfg_q,
  output logic              std_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      std_q <= 1'b0;
    end else if (load) begin
      cfg_q <= vsp_cfg_t'(ctrl_in);
      std_q <= std_in;
    end
  end
endmodule

// File: rtl/vsp_window.sv
module vsp_window
  import vsp_pkg::*;
#(
  parameter int HL_W = 10
) (
  input  logic [HL_W-1:0] pos,
  input  logic [HL_W-1:0] field_len,
  input  vsp_cfg_t        cfg,
  output logic            hit
);
  int remain;
  int lead;
  int width;

  always_comb begin
    remain = int'(field_len) - int'(pos);
    lead   = int'(cfg.lead) + LEAD_BASE;
    width  = int'(cfg.width);
    hit    = (remain <= lead) && (remain + width > lead);
  end
endmodule

// File: rtl/vsp_top.sv
module vsp_top
  import vsp_pkg::*;
#(
  parameter int FIELD_HL_50 = 625,
  parameter int FIELD_HL_60 = 525
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hl_stb,
  input  logic              vs_mark,
  input  logic              std_60,
  input  logic [CTRL_W-1:0] ctrl_byte,
  output logic              pre_vs_pulse
);
  localparam int FIELD_MAX = (FIELD_HL_50 > FIELD_HL_60) ? FIELD_HL_50 : FIELD_HL_60;
  localparam int HL_W      = $clog2(FIELD_MAX + 1);

  logic [HL_W-1:0] hl_cnt;
  logic [HL_W-1:0] hl_next;
  logic [HL_W-1:0] field_len;
  logic            field_start;
  logic            std_q;
  logic            in_window;
  vsp_cfg_t        cfg_q;

  assign field_len = std_q ? HL_W'(FIELD_HL_60) : HL_W'(FIELD_HL_50);

  vsp_hl_counter #(.HL_W(HL_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .stb         (hl_stb),
    .vs          (vs_mark),
    .field_len   (field_len),
    .cnt         (hl_cnt),
    .cnt_next    (hl_next),
    .field_start (field_start)
  );

  vsp_cfg_shadow u_shadow (
    .clk     (clk),
    .rst     (rst),
    .load    (field_start),
    .ctrl_in (ctrl_byte),
    .std_in  (std_60),
    .cfg_q   (cfg_q),
    .std_q   (std_q)
  );

  vsp_window #(.HL_W(HL_W)) u_win (
    .pos       (hl_next),
    .field_len (field_len),
    .cfg       (cfg_q),
    .hit       (in_window)
  );

  always_ff @(posedge clk) begin
    if (rst)         pre_vs_pulse <= 1'b0;
    else if (hl_stb) pre_vs_pulse <= in_window;
  end
endmodule

// File: rtl/vsp_checker.sv
module vsp_checker #(
  parameter int HL_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            hl_stb,
  input logic            vs_mark,
  input logic            pulse,
  input logic [HL_W-1:0] cnt,
  input logic [HL_W-1:0] field_len,
  input logic [7:0]      cfg_bits
);
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !pulse);

  a_r8_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
    !hl_stb |=> $stable(pulse));

  a_r2_marker_clears: assert property (@(posedge clk) disable iff (rst)
    (hl_stb && vs_mark) |=> (cnt == '0 && !pulse));

  a_r3_index_in_field: assert property (@(posedge clk) disable iff (rst)
    cnt < field_len);

  a_r5_zero_width_silent: assert property (@(posedge clk) disable iff (rst)
    (cfg_bits[7:4] == 4'd0) |-> !pulse);

  a_r6_low_at_sync: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> !pulse);

  a_r4_rise_at_lead: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> (int'(field_len) - int'(cnt) == int'(cfg_bits[3:0]) + 3));
endmodule

bind vsp_top vsp_checker #(.HL_W(HL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hl_stb    (hl_stb),
  .vs_mark   (vs_mark),
  .pulse     (pre_vs_pulse),
  .cnt       (hl_cnt),
  .field_len (field_len),
  .cfg_bits  (cfg_q)
);

// File: tb/tb_vsp_top.sv
`timescale 1ns/1ps
module tb_vsp_top;
  localparam int F50 = 61;
  localparam int F60 = 47;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hl_stb = 1'b0;
  logic       vs_mark = 1'b0;
  logic       std_60 = 1'b0;
  logic [7:0] ctrl_byte = 8'h00;
  logic       pre_vs_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int    m_cnt = 0, m_std = 0, m_w = 0, m_c = 0, m_out = 0;
  int    hi_cnt = 0, rise_idx = -1;
  string tag = "R1";

  always #2 clk = ~clk;

  vsp_top #(.FIELD_HL_50(F50), .FIELD_HL_60(F60)) dut (
    .clk(clk), .rst(rst), .hl_stb(hl_stb), .vs_mark(vs_mark),
    .std_60(std_60), .ctrl_byte(ctrl_byte), .pre_vs_pulse(pre_vs_pulse));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int flen(input int s);
    return s ? F60 : F50;
  endfunction

  // one clock: drive, advance model, compare
  task automatic step(input bit stb, input bit vs);
    int len, nxt, rem, lead, prev;
    bit fs;
    hl_stb = stb; vs_mark = vs;
    prev = m_out;
    @(posedge clk); #1;
    if (stb) begin
      len = flen(m_std);
      fs  = vs || (m_cnt == len - 1);
      nxt = fs ? 0 : m_cnt + 1;
      rem = len - nxt;
      lead = m_c + 3;
      m_out = (rem <= lead && rem + m_w > lead) ? 1 : 0;
      if (m_out && !prev) rise_idx = nxt;
      if (fs) begin
        if (!vs) begin
          // whole field completed by wrap: length and start position
          if (m_w > lead) check("R6 cut at sync length", hi_cnt, lead);
          else            check("R5 pulse length", hi_cnt, m_w);
          if (m_w > 0) check("R4 rise index", rise_idx, len - lead);
        end
        hi_cnt = 0; rise_idx = -1;
        m_w = ctrl_byte[7:4]; m_c = ctrl_byte[3:0]; m_std = std_60;
      end else if (m_out) hi_cnt++;
      m_cnt = nxt;
    end else begin
      check("R8 no change without strobe", pre_vs_pulse, prev);
    end
    check(tag, pre_vs_pulse, m_out);
  endtask

  task automatic run_hl(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
    end
  endtask

  task automatic mark();
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ctrl_byte = 8'h52;
    repeat (3) @(posedge clk);
    #1;
    check("R1 output low in reset", pre_vs_pulse, 0);
    rst = 1'b0;
    // R1/R7: control byte present but not loaded before a field start
    tag = "R1 low until first field start";
    run_hl(30);
    // R2: marker starts a field, loads width 5 lead code 2
    tag = "R2 marker restart";
    mark();
    tag = "R4 lead position";
    run_hl(3 * F50);
    // R7: change control mid-field, current field must be unaffected
    tag = "R7 mid-field write ignored";
    run_hl(20);
    ctrl_byte = 8'hF0;              // width 15, lead 3 -> cut at sync
    std_60 = 1'b1;
    run_hl(F50 - 20);
    tag = "R6 cut at sync";
    run_hl(2 * F60);
    // R3: 60 Hz wraps, lead code 15 width 15
    ctrl_byte = 8'hFF;
    tag = "R3 60Hz wrap";
    run_hl(3 * F60);
    // R5: width 0
    ctrl_byte = 8'h07;
    std_60 = 1'b0;
    tag = "R5 zero width";
    run_hl(F60 + 2 * F50);
    // R9: early marker in the middle of a pulse
    ctrl_byte = 8'hA6;              // width 10, lead 9
    run_hl(F50);
    tag = "R9 early marker";
    run_hl(F50 - 5);
    check("R9 pulse high before early marker", pre_vs_pulse, 1);
    mark();
    check("R9 pulse dropped by early marker", pre_vs_pulse, 0);
    run_hl(2 * F50);
    // R2: marker without strobe has no effect
    tag = "R2 marker needs strobe";
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
    end
    run_hl(2 * F50);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule